// File: doc/BRIEF.md
# History-Indexed Indirect Jump Target Predictor

This block predicts the destination of register-indirect jumps, the kind produced by switch tables and virtual calls. An indirect jump is always taken, so the block gives no direction guess. It only suggests where fetch should go next. Targets are kept in a direct-mapped table. The entry for a jump is selected by XORing a slice of the jump's PC with a global history of recent conditional branch outcomes. Because the history changes, one jump can own several entries, each holding a different target. The cost is that a jump can also collide with entries that belong to other branches.

At fetch the block returns a hit flag, a predicted target and the table index it used. The fetch unit carries that index along with the jump. When the jump resolves, the backend hands the index back together with the real target, and the block writes that entry. The write therefore lands on the entry that was read, even if the history has moved on since fetch. Each entry holds a valid bit, a partial tag taken from the PC bits just above the index field, and the full target. On a miss the fetch unit falls back to the sequential address. History is shifted by the conditional-branch side of the machine through a separate input.

Top module: `indirect_target_pred`

## Requirements
- R1: After reset every lookup misses (predHit low) and the history register reads zero.
- R2: The lookup index is fetchPc[9:2] XOR history[7:0], presented on predIdx in the same cycle as fetchPc.
- R3: Each cycle with histValid high shifts histTaken into history bit 0, moves every older bit up one place and drops bit 7. Without histValid the history holds its value.
- R4: A cycle with resValid high writes entry resIdx with valid set, tag resPc[17:10] and target resTarget. The new contents are visible to lookups from the next cycle on.
- R5: A lookup hits only when the selected entry is valid and its stored tag equals fetchPc[17:10]. A tag mismatch at a valid entry is a miss.
- R6: On a miss predHit is low and predTarget is all zeros. On a hit predTarget is the stored target.
- R7: The same jump PC looked up under two histories that give different indices returns the target stored for each history separately.
- R8: A resolve writes the carried index resIdx, whatever the history holds when the resolve arrives.
- R9: When a lookup and a resolve address the same entry in the same cycle, the lookup returns the contents from before the write.
- R10: With fetchValid low, predHit is low even when the addressed entry would hit.
- R11: A resolve to an entry that is already in use replaces its tag and target, so the previous owner misses from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchValid | input | 1 | An indirect jump is being fetched this cycle |
| fetchPc | input | 32 | PC of the fetched jump |
| predHit | output | 1 | Lookup found a matching valid entry |
| predTarget | output | 32 | Predicted target, zero on a miss |
| predIdx | output | 8 | Table index used by this lookup, carried with the jump |
| histValid | input | 1 | A conditional branch resolved this cycle |
| histTaken | input | 1 | Outcome of that conditional branch (1 = taken) |
| histOut | output | 8 | Current global history |
| resValid | input | 1 | An indirect jump resolved this cycle |
| resPc | input | 32 | PC of the resolved jump |
| resIdx | input | 8 | Index carried from that jump's fetch |
| resTarget | input | 32 | Actual target of the resolved jump |

## Verification
The bench builds the block with its default parameters: a 256-entry table, 8 history bits and an 8-bit tag taken from PC bits 17:10. With these values the bench can load any history with eight shifts. It can also make two PCs that differ only in bit 10 land on the same entry with different tags. That makes aliasing, eviction and same-entry read/write collisions easy to set up. It also lets one jump PC be placed in two distinct entries by changing only the history.

// File: rtl/itp_pkg.sv
package itp_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic lookupEn;   // a fetch lookup is active
    logic tableWr;    // write the carried index
    logic histShift;  // shift one outcome into history
  } itpStrobe_t;
endpackage

// File: rtl/itp_ctrl.sv
module itp_ctrl
  import itp_pkg::*;
(
  input  logic       fetchValid,
  input  logic       histValid,
  input  logic       resValid,
  output itpStrobe_t strb
);
  always_comb begin
    strb.lookupEn  = fetchValid;
    strb.tableWr   = resValid;
    strb.histShift = histValid;
  end
endmodule

// File: rtl/itp_datapath.sv
module itp_datapath
  import itp_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 8,
  parameter int GHR_W = 8,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  itpStrobe_t       strb,
  input  logic [PC_W-1:0]  fetchPc,
  input  logic             histTaken,
  input  logic [PC_W-1:0]  resPc,
  input  logic [IDX_W-1:0] resIdx,
  input  logic [PC_W-1:0]  resTarget,
  output logic             predHit,
  output logic [PC_W-1:0]  predTarget,
  output logic [IDX_W-1:0] predIdx,
  output logic [GHR_W-1:0] histOut
);
  localparam int DEPTH  = 1 << IDX_W;
  localparam int IDX_LO = 2;
  localparam int TAG_LO = IDX_LO + IDX_W;
  localparam int TAG_HI = TAG_LO + TAG_W - 1;

  logic [GHR_W-1:0] ghr;
  logic [IDX_W-1:0] histSlice;
  logic [DEPTH-1:0] validVec;
  logic [TAG_W-1:0] tagMem [DEPTH];
  logic [PC_W-1:0]  tgtMem [DEPTH];
  logic [TAG_W-1:0] fetchTag;
  logic [TAG_W-1:0] resTag;
  logic             tagMatch;

  // Fit history to the index width
  generate
    if (GHR_W >= IDX_W) begin : g_histTrunc
      assign histSlice = ghr[IDX_W-1:0];
    end else begin : g_histExt
      assign histSlice = {{(IDX_W-GHR_W){1'b0}}, ghr};
    end
  endgenerate

  assign predIdx  = fetchPc[TAG_LO-1:IDX_LO] ^ histSlice;
  assign fetchTag = fetchPc[TAG_HI:TAG_LO];
  assign resTag   = resPc[TAG_HI:TAG_LO];
  assign histOut  = ghr;

  logic unusedPcBits;
  assign unusedPcBits = ^{fetchPc[IDX_LO-1:0], fetchPc[PC_W-1:TAG_HI+1],
                          resPc[TAG_LO-1:0], resPc[PC_W-1:TAG_HI+1]};

  // History register and valid bits
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ghr      <= '0;
      validVec <= '0;
    end else begin
      if (strb.histShift) ghr <= {ghr[GHR_W-2:0], histTaken};
      if (strb.tableWr)   validVec[resIdx] <= 1'b1;
    end
  end

  // Tag and target storage, no reset
  always_ff @(posedge clk) begin
    if (strb.tableWr) begin
      tagMem[resIdx] <= resTag;
      tgtMem[resIdx] <= resTarget;
    end
  end

  // Read happens before the write of the same cycle
  assign tagMatch   = (tagMem[predIdx] == fetchTag);
  assign predHit    = strb.lookupEn & validVec[predIdx] & tagMatch;
  assign predTarget = predHit ? tgtMem[predIdx] : '0;

  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.histShift |=> $stable(ghr)); // R3
  AST_WRITE_SETS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    strb.tableWr |=> validVec[$past(resIdx)]); // R4
  AST_NO_WRITE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.tableWr |=> $stable(validVec)); // R4
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !predHit |-> (predTarget == '0)); // R6
  AST_HIT_NEEDS_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    predHit |-> strb.lookupEn); // R10
endmodule

// File: rtl/indirect_target_pred.sv
module indirect_target_pred
  import itp_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 8,
  parameter int GHR_W = 8,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fetchValid,
  input  logic [PC_W-1:0]  fetchPc,
  output logic             predHit,
  output logic [PC_W-1:0]  predTarget,
  output logic [IDX_W-1:0] predIdx,
  input  logic             histValid,
  input  logic             histTaken,
  output logic [GHR_W-1:0] histOut,
  input  logic             resValid,
  input  logic [PC_W-1:0]  resPc,
  input  logic [IDX_W-1:0] resIdx,
  input  logic [PC_W-1:0]  resTarget
);
  itpStrobe_t strb;

  itp_ctrl ctrl_i (
    .fetchValid (fetchValid),
    .histValid  (histValid),
    .resValid   (resValid),
    .strb       (strb)
  );

  itp_datapath #(
    .PC_W (PC_W), .IDX_W (IDX_W), .GHR_W (GHR_W), .TAG_W (TAG_W)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .fetchPc    (fetchPc),
    .histTaken  (histTaken),
    .resPc      (resPc),
    .resIdx     (resIdx),
    .resTarget  (resTarget),
    .predHit    (predHit),
    .predTarget (predTarget),
    .predIdx    (predIdx),
    .histOut    (histOut)
  );
endmodule

// File: tb/indirect_target_pred_tb.sv
module indirect_target_pred_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fetchValid = 1'b0;
  logic [31:0] fetchPc = '0;
  logic        predHit;
  logic [31:0] predTarget;
  logic [7:0]  predIdx;
  logic        histValid = 1'b0;
  logic        histTaken = 1'b0;
  logic [7:0]  histOut;
  logic        resValid = 1'b0;
  logic [31:0] resPc = '0;
  logic [7:0]  resIdx = '0;
  logic [31:0] resTarget = '0;

  int checks = 0;
  int fails = 0;
  logic [7:0] tbGhr = '0;

  always #10 clk = ~clk; // 50 MHz

  indirect_target_pred dut_i (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchPc(fetchPc),
    .predHit(predHit), .predTarget(predTarget), .predIdx(predIdx),
    .histValid(histValid), .histTaken(histTaken), .histOut(histOut),
    .resValid(resValid), .resPc(resPc), .resIdx(resIdx), .resTarget(resTarget)
  );

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expIdx(input logic [31:0] pc);
    return pc[9:2] ^ tbGhr;
  endfunction

  task automatic shiftIn(input logic b);
    @(negedge clk); histValid = 1'b1; histTaken = b;
    @(posedge clk); #1 histValid = 1'b0;
    tbGhr = {tbGhr[6:0], b};
  endtask

  task automatic setHist(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) shiftIn(v[i]);
  endtask

  // Drive a lookup; outputs are sampled 1 ns after the falling edge
  task automatic lookup(input logic [31:0] pc, output logic hit,
                        output logic [31:0] tgt, output logic [7:0] idx);
    @(negedge clk); fetchValid = 1'b1; fetchPc = pc;
    #1 hit = predHit; tgt = predTarget; idx = predIdx;
    @(posedge clk); #1 fetchValid = 1'b0;
  endtask

  task automatic resolve(input logic [31:0] pc, input logic [7:0] idx,
                         input logic [31:0] tgt);
    @(negedge clk); resValid = 1'b1; resPc = pc; resIdx = idx; resTarget = tgt;
    @(posedge clk); #1 resValid = 1'b0;
  endtask

  localparam logic [31:0] PC_A = 32'h0001_2344;
  localparam logic [31:0] PC_B = PC_A ^ 32'h0000_0400; // same index bits, tag differs

  task automatic testReset();
    logic h; logic [31:0] t; logic [7:0] x;
    check(histOut == 8'h00, "R1 history zero", {24'h0, histOut}, 32'h0);
    lookup(PC_A, h, t, x);
    check(!h, "R1 miss after reset", {31'h0, h}, 32'h0);
    check(t == 32'h0, "R6 miss target zero", t, 32'h0);
  endtask

  task automatic testHistory();
    setHist(8'h00);
    shiftIn(1'b1); shiftIn(1'b0); shiftIn(1'b1); shiftIn(1'b1);
    check(histOut == 8'h0B, "R3 shift order", {24'h0, histOut}, 32'h0B);
    setHist(8'hC3); shiftIn(1'b0);
    check(histOut == 8'h86, "R3 msb dropped", {24'h0, histOut}, 32'h86);
    repeat (3) @(posedge clk);
    #1 check(histOut == 8'h86, "R3 hold without strobe", {24'h0, histOut}, 32'h86);
  endtask

  task automatic testIndexAndSplit();
    logic h; logic [31:0] t; logic [7:0] x0, x1, xd;
    setHist(8'h5A);
    lookup(PC_A, h, t, x0);
    check(x0 == expIdx(PC_A), "R2 index", {24'h0, x0}, {24'h0, expIdx(PC_A)});
    resolve(PC_A, x0, 32'hAAAA_0000);
    lookup(PC_A, h, t, xd);
    check(h && t == 32'hAAAA_0000, "R4 written entry hits", t, 32'hAAAA_0000);
    setHist(8'h3C);
    lookup(PC_A, h, t, x1);
    check(x1 == expIdx(PC_A), "R2 index other history", {24'h0, x1}, {24'h0, expIdx(PC_A)});
    check(!h, "R7 new history misses", {31'h0, h}, 32'h0);
    resolve(PC_A, x1, 32'hBBBB_0000);
    lookup(PC_A, h, t, xd);
    check(h && t == 32'hBBBB_0000, "R7 second target", t, 32'hBBBB_0000);
    setHist(8'h5A);
    lookup(PC_A, h, t, xd);
    check(h && t == 32'hAAAA_0000, "R7 first target kept", t, 32'hAAAA_0000);
  endtask

  task automatic testCarriedIndex();
    logic h; logic [31:0] t; logic [7:0] x, xd;
    setHist(8'h11);
    lookup(PC_A, h, t, x);
    setHist(8'hE7);  // history moves on before resolve
    resolve(PC_A, x, 32'hCCCC_0000);
    setHist(8'h11);
    lookup(PC_A, h, t, xd);
    check(h && t == 32'hCCCC_0000, "R8 carried index written", t, 32'hCCCC_0000);
  endtask

  task automatic testTagAndEvict();
    logic h; logic [31:0] t; logic [7:0] xa, xb;
    setHist(8'h11);
    lookup(PC_B, h, t, xb);
    lookup(PC_A, h, t, xa);
    check(xa == xb, "R5 alias same index", {24'h0, xb}, {24'h0, xa});
    lookup(PC_B, h, t, xb);
    check(!h && t == 32'h0, "R5 tag mismatch misses", {31'h0, h}, 32'h0);
    resolve(PC_B, xb, 32'hDDDD_0000);
    lookup(PC_B, h, t, xb);
    check(h && t == 32'hDDDD_0000, "R11 new owner hits", t, 32'hDDDD_0000);
    lookup(PC_A, h, t, xa);
    check(!h, "R11 old owner evicted", {31'h0, h}, 32'h0);
  endtask

  task automatic testCollision();
    logic h; logic [31:0] t; logic [7:0] x;
    setHist(8'h11);
    lookup(PC_B, h, t, x);
    @(negedge clk);
    fetchValid = 1'b1; fetchPc = PC_B;
    resValid = 1'b1; resPc = PC_B; resIdx = x; resTarget = 32'hEEEE_0000;
    #1 check(predHit && predTarget == 32'hDDDD_0000, "R9 old data same cycle",
             predTarget, 32'hDDDD_0000);
    @(posedge clk); #1 resValid = 1'b0;
    check(predHit && predTarget == 32'hEEEE_0000, "R9 new data next cycle",
          predTarget, 32'hEEEE_0000);
    fetchValid = 1'b0;
    #1 check(!predHit && predTarget == 32'h0, "R10 no fetch no hit",
             {31'h0, predHit}, 32'h0);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testHistory();
    testIndexAndSplit();
    testCarriedIndex();
    testTagAndEvict();
    testCollision();
    repeat (2) @(posedge clk);
    finishRun();
  end
endmodule